// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the software-visible control and status word for every channel of a multi-channel DMA engine, plus one summary word that folds all channels' interrupt causes together. Each channel word carries the run bit and the mode bits the transfer engine needs. It also reflects two live status inputs. It keeps four sticky event flags that the engine raises with one-cycle pulses, and a compare-status bit that software sets and clears through two command bits.

Software reaches the bank through a simple register port: one byte address, a write strobe with write data, and combinational read data. Channel n occupies byte address 4·n, and the summary word sits at a separate, parameterised address. A typical interrupt handler reads the summary word to find the active channels. It then reads each flagged channel word and writes the same value back. Only the flags that were seen are cleared, while flags raised in the meantime are kept.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every channel word reads 0, all control outputs are low and `irq` is low.
- R2: Bits 31 (run), 30 (no-descriptor-fetch mode), 29 (stop interrupt enable), 28 (end-of-receive interrupt enable), 27 (jump on end-of-receive) and 26 (stop on end-of-receive) are read/write, take the written value one cycle after the write, and drive `run`, `nodesc`, `eor_jump` and `eor_stop` for that channel.
- R3: Bit 8 reads the channel's `req_pend` input and bit 3 its `stopped` input, live; writes to these bits have no effect.
- R4: A one-cycle pulse on `ev_buserr`, `ev_start`, `ev_end` or `ev_eor` sets bit 0, 1, 2 or 9 respectively from the next cycle on, and the flag stays set.
- R5: Writing 1 to bit 0, 1, 2 or 9 clears that flag; writing 0 leaves it unchanged, so writing back a value just read clears exactly the flags it showed.
- R6: When an event pulse and a clearing write reach the same flag in the same cycle, the flag is set afterwards.
- R7: Writing 1 to bit 25 sets the compare-status bit 10, writing 1 to bit 24 clears it, and writing both sets it; bits 25 and 24 read 0.
- R8: A write changes only the channel whose byte address 4·n matches exactly; writes to the summary address, to misaligned addresses or to unmapped addresses change no state.
- R9: Summary bit n reads 1 when channel n has bit 0, 1 or 2 set, or bit 9 set with bit 28 set, or `stopped` high with bit 29 set; the upper summary bits read 0.
- R10: `irq` is high exactly while the summary word is non-zero.
- R11: Reads of unmapped or misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data at `addr` |
| ev_start | input | NUM_CH | Per-channel start event pulse |
| ev_end | input | NUM_CH | Per-channel end event pulse |
| ev_buserr | input | NUM_CH | Per-channel bus error event pulse |
| ev_eor | input | NUM_CH | Per-channel end-of-receive event pulse |
| req_pend | input | NUM_CH | Per-channel live peripheral request pending |
| stopped | input | NUM_CH | Per-channel live stopped state |
| run | output | NUM_CH | Per-channel run control |
| nodesc | output | NUM_CH | Per-channel no-descriptor-fetch mode |
| eor_jump | output | NUM_CH | Per-channel jump on end-of-receive |
| eor_stop | output | NUM_CH | Per-channel stop on end-of-receive |
| irq | output | 1 | Combined interrupt |

## Verification
The engine's event pulse and software's write-one-to-clear of the same flag can land in the same clock. The bench provokes this directly by pulsing `ev_end` while writing 1 to bit 2 of that channel. It then reads the word back and expects the flag to remain set. A long pseudo-random phase keeps both kinds of traffic dense on all channels. The phase drives random event vectors together with random writes, some of them with write-back values. A behavioural model applies event-over-clear priority and is compared against `rd_data`, `irq` and the control outputs on every clock.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

   localparam int DATA_W = 32;

   // Control field positions (read/write)
   localparam int B_RUN      = 31;
   localparam int B_NODESC   = 30;
   localparam int B_STOP_IE  = 29;
   localparam int B_EOR_IE   = 28;
   localparam int B_EOR_JUMP = 27;
   localparam int B_EOR_STOP = 26;
   // Command bits (write only, read as zero)
   localparam int B_CMP_SET  = 25;
   localparam int B_CMP_CLR  = 24;
   // Status
   localparam int B_CMP      = 10;
   localparam int B_EOR      = 9;
   localparam int B_REQ      = 8;
   localparam int B_STOPPED  = 3;
   localparam int B_END      = 2;
   localparam int B_START    = 1;
   localparam int B_BUSERR   = 0;

   localparam int N_FLAGS = 4;
   localparam int CTL_W   = 6;

   typedef enum logic [1:0] {
      FL_BUSERR = 2'd0,
      FL_START  = 2'd1,
      FL_END    = 2'd2,
      FL_EOR    = 2'd3
   } flag_e;

   typedef struct packed {
      logic run;
      logic nodesc;
      logic stop_ie;
      logic eor_ie;
      logic eor_jump;
      logic eor_stop;
   } ctl_t;

   function automatic int flag_pos(input int idx);
      case (idx)
         0:       return B_BUSERR;
         1:       return B_START;
         2:       return B_END;
         default: return B_EOR;
      endcase
   endfunction

endpackage

// File: rtl/dma_csr_flag.sv
module dma_csr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o); // R4

   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o); // R5

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o); // R5

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> q_o); // R6

endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
   import dma_csr_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic [N_FLAGS-1:0]  ev_i,
   input  logic                req_i,
   input  logic                stopped_i,
   output logic [DATA_W-1:0]   rd_o,
   output ctl_t                ctl_o,
   output logic                int_o
);

   ctl_t               ctl_q;
   logic               cmp_q;
   logic [N_FLAGS-1:0] flags;
   logic               unused_wbits;

   assign unused_wbits = ^{wdata_i[23:10], wdata_i[8:3]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctl_q <= '0;
      else if (wr_i) ctl_q <= ctl_t'(wdata_i[B_RUN:B_EOR_STOP]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cmp_q <= 1'b0;
      else if (wr_i && wdata_i[B_CMP_SET]) cmp_q <= 1'b1;
      else if (wr_i && wdata_i[B_CMP_CLR]) cmp_q <= 1'b0;
   end

   for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
      localparam int P = flag_pos(f);
      dma_csr_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (ev_i[f]),
         .clr_i (wr_i & wdata_i[P]),
         .q_o   (flags[f])
      );
   end

   always_comb begin
      rd_o = '0;
      rd_o[B_RUN:B_EOR_STOP] = ctl_q;
      rd_o[B_CMP]     = cmp_q;
      rd_o[B_REQ]     = req_i;
      rd_o[B_STOPPED] = stopped_i;
      for (int f = 0; f < N_FLAGS; f++) rd_o[flag_pos(f)] = flags[f];
   end

   assign int_o = flags[FL_BUSERR] | flags[FL_START] | flags[FL_END]
                | (flags[FL_EOR] & ctl_q.eor_ie)
                | (stopped_i & ctl_q.stop_ie);

   assign ctl_o = ctl_q;

   AST_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (ctl_o.run == $past(wdata_i[B_RUN]))); // R2

   AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[B_CMP_SET]) |=> rd_o[B_CMP]); // R7

   AST_CMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[B_CMP_CLR] && !wdata_i[B_CMP_SET]) |=> !rd_o[B_CMP]); // R7

endmodule

// File: rtl/dma_csr_decode.sv
module dma_csr_decode #(
   parameter int          NUM_CH   = 8,
   parameter int          ADDR_W   = 9,
   parameter int unsigned SUM_ADDR = 256
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NUM_CH-1:0] ch_sel_o,
   output logic              sum_sel_o
);

   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              aligned;

   assign word    = addr_i[ADDR_W-1:2];
   assign aligned = (addr_i[1:0] == 2'b00);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
      assign ch_sel_o[c] = aligned && (word == WORD_W'(c));
   end

   assign sum_sel_o = (addr_i == ADDR_W'(SUM_ADDR));

endmodule

// File: rtl/dma_csr_summary.sv
module dma_csr_summary #(
   parameter int NUM_CH  = 8,
   parameter int IRQ_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] int_req_i,
   output logic [NUM_CH-1:0] summary_o,
   output logic              irq_o
);

   assign summary_o = int_req_i;

   if (IRQ_REG != 0) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= |int_req_i;
      end
   end else begin : g_irq_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o = |int_req_i;
   end

endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux #(
   parameter int NUM_CH = 8,
   parameter int DW     = 32
) (
   input  logic [NUM_CH-1:0]         ch_sel_i,
   input  logic                      sum_sel_i,
   input  logic [NUM_CH-1:0][DW-1:0] ch_rd_i,
   input  logic [NUM_CH-1:0]         summary_i,
   output logic [DW-1:0]             rd_o
);

   always_comb begin
      rd_o = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_sel_i[c]) rd_o = rd_o | ch_rd_i[c];
      end
      if (sum_sel_i) rd_o = rd_o | DW'(summary_i);
   end

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
   import dma_csr_pkg::*;
#(
   parameter int          NUM_CH   = 8,
   parameter int          ADDR_W   = 9,
   parameter int unsigned SUM_ADDR = 256,
   parameter int          IRQ_REG  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   input  logic [NUM_CH-1:0] ev_start,
   input  logic [NUM_CH-1:0] ev_end,
   input  logic [NUM_CH-1:0] ev_buserr,
   input  logic [NUM_CH-1:0] ev_eor,
   input  logic [NUM_CH-1:0] req_pend,
   input  logic [NUM_CH-1:0] stopped,
   output logic [NUM_CH-1:0] run,
   output logic [NUM_CH-1:0] nodesc,
   output logic [NUM_CH-1:0] eor_jump,
   output logic [NUM_CH-1:0] eor_stop,
   output logic              irq
);

   localparam int BANK_BYTES = 4 * NUM_CH;

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_nch
      $error("NUM_CH must lie in 1..32");
   end
   if (ADDR_W < 3 || ADDR_W > 31) begin : g_bad_aw
      $error("ADDR_W must lie in 3..31");
   end
   if (BANK_BYTES > (1 << ADDR_W)) begin : g_bad_fit
      $error("channel bank does not fit the address space");
   end
   if (SUM_ADDR % 4 != 0 || SUM_ADDR < BANK_BYTES || SUM_ADDR >= (1 << ADDR_W)) begin : g_bad_sum
      $error("SUM_ADDR must be word aligned, above the bank and inside the address space");
   end
   if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
      $error("IRQ_REG must be 0 or 1");
   end

   logic [NUM_CH-1:0]             ch_sel;
   logic                          sum_sel;
   logic [NUM_CH-1:0][DATA_W-1:0] ch_rd;
   logic [NUM_CH-1:0]             int_req;
   logic [NUM_CH-1:0]             summary;

   dma_csr_decode #(
      .NUM_CH   (NUM_CH),
      .ADDR_W   (ADDR_W),
      .SUM_ADDR (SUM_ADDR)
   ) u_dec (
      .addr_i    (addr),
      .ch_sel_o  (ch_sel),
      .sum_sel_o (sum_sel)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ctl_t ctl;
      dma_csr_chan u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_i      (wr_en & ch_sel[c]),
         .wdata_i   (wr_data),
         .ev_i      ({ev_eor[c], ev_end[c], ev_start[c], ev_buserr[c]}),
         .req_i     (req_pend[c]),
         .stopped_i (stopped[c]),
         .rd_o      (ch_rd[c]),
         .ctl_o     (ctl),
         .int_o     (int_req[c])
      );
      assign run[c]      = ctl.run;
      assign nodesc[c]   = ctl.nodesc;
      assign eor_jump[c] = ctl.eor_jump;
      assign eor_stop[c] = ctl.eor_stop;

      AST_UNSELECTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && ch_sel[c]) |=> $stable(run[c])); // R8
   end

   dma_csr_summary #(
      .NUM_CH  (NUM_CH),
      .IRQ_REG (IRQ_REG)
   ) u_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .int_req_i (int_req),
      .summary_o (summary),
      .irq_o     (irq)
   );

   dma_csr_rdmux #(
      .NUM_CH (NUM_CH),
      .DW     (DATA_W)
   ) u_rd (
      .ch_sel_i  (ch_sel),
      .sum_sel_i (sum_sel),
      .ch_rd_i   (ch_rd),
      .summary_i (summary),
      .rd_o      (rd_data)
   );

endmodule

// File: tb/sim_dma_csr_bank.sv
module sim_dma_csr_bank;

   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 8;
   localparam int AW    = 9;
   localparam int SUM_A = 256;
   localparam int unsigned CTL_M = 32'hFC00_0000;
   localparam int unsigned FLG_M = 32'h0000_0207;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [NCH-1:0] ev_start = '0, ev_end = '0, ev_buserr = '0, ev_eor = '0;
   logic [NCH-1:0] req_pend = '0, stopped = '0;
   logic [31:0] rd_data;
   logic [NCH-1:0] run, nodesc, eor_jump, eor_stop;
   logic irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_csr_bank u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .ev_start(ev_start), .ev_end(ev_end),
      .ev_buserr(ev_buserr), .ev_eor(ev_eor), .req_pend(req_pend),
      .stopped(stopped), .run(run), .nodesc(nodesc), .eor_jump(eor_jump),
      .eor_stop(eor_stop), .irq(irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   int unsigned m_ctl [NCH];
   int unsigned m_flg [NCH];
   bit          m_cmp [NCH];

   function automatic int unsigned model_sum();
      int unsigned s = 0;
      for (int c = 0; c < NCH; c++) begin
         if ((m_flg[c] & 32'h7) != 0 ||
             (m_flg[c][9] && m_ctl[c][28]) ||
             (stopped[c] && m_ctl[c][29]))
            s = s | (32'h1 << c);
      end
      return s;
   endfunction

   function automatic int unsigned model_read(int a);
      if (a == SUM_A) return model_sum();
      if (a % 4 == 0 && a / 4 < NCH) begin
         int c = a / 4;
         return m_ctl[c] | m_flg[c] | (m_cmp[c] ? 32'h400 : 32'h0) |
                (req_pend[c] ? 32'h100 : 32'h0) | (stopped[c] ? 32'h8 : 32'h0);
      end
      return 0;
   endfunction

   function automatic int unsigned model_bit(int b);
      int unsigned v = 0;
      for (int c = 0; c < NCH; c++) if (m_ctl[c][b]) v = v | (32'h1 << c);
      return v;
   endfunction

   // behavioural reference, updated on the same edge as the design
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_ctl[c] = 0; m_flg[c] = 0; m_cmp[c] = 0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            int unsigned ev;
            ev = (ev_eor[c] ? 32'h200 : 0) | (ev_end[c] ? 32'h4 : 0) |
                 (ev_start[c] ? 32'h2 : 0) | (ev_buserr[c] ? 32'h1 : 0);
            if (wr_en && int'(addr) == 4 * c) begin
               m_flg[c] = ev | (m_flg[c] & ~(wr_data & FLG_M));
               m_ctl[c] = wr_data & CTL_M;
               if (wr_data[25])      m_cmp[c] = 1;
               else if (wr_data[24]) m_cmp[c] = 0;
            end else begin
               m_flg[c] = ev | m_flg[c];
            end
         end
      end
   end

   task automatic check(string tag, int unsigned act, int unsigned exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      check("R8 R3 R4 read", rd_data, model_read(int'(addr)));
      check("R10 irq", 32'(irq), (model_sum() != 0) ? 1 : 0);
      check("R2 run", 32'(run), model_bit(31));
      check("R2 nodesc", 32'(nodesc), model_bit(30));
      check("R2 eor_jump", 32'(eor_jump), model_bit(27));
      check("R2 eor_stop", 32'(eor_stop), model_bit(26));
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
      ev_start = '0; ev_end = '0; ev_buserr = '0; ev_eor = '0;
      wr_en = 1'b0;
   endtask

   task automatic wr(int a, int unsigned d);
      addr = AW'(a); wr_en = 1'b1; wr_data = d;
      cyc();
   endtask

   task automatic rd_chk(int a, int unsigned exp, string tag);
      addr = AW'(a);
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int unsigned r;
      repeat (2) @(negedge clk);
      // R1: reset state
      rd_chk(0, 0, "R1 ch0");
      rd_chk(28, 0, "R1 ch7");
      check("R1 irq", 32'(irq), 0);
      check("R1 run", 32'(run), 0);
      rst_n = 1'b1;
      cyc();

      // R2: control fields
      wr(0, 32'hC000_0000);
      rd_chk(0, 32'hC000_0000, "R2 ch0");
      check("R2 run0", 32'(run[0]), 1);
      check("R2 nodesc0", 32'(nodesc[0]), 1);
      wr(12, 32'hFC00_00FF);
      rd_chk(12, 32'hFC00_0000, "R2 ch3");
      check("R2 jump3", 32'(eor_jump[3]), 1);
      check("R2 stop3", 32'(eor_stop[3]), 1);

      // R3: live read-only status
      req_pend[2] = 1'b1; stopped[2] = 1'b1;
      addr = 8; cyc();
      rd_chk(8, 32'h108, "R3 live");
      wr(8, 32'h0000_0108);
      rd_chk(8, 32'h108, "R3 write ignored");
      rd_chk(SUM_A, 0, "R9 stop without enable");

      // R4: event flags
      ev_start[1] = 1'b1; cyc();
      ev_end[1] = 1'b1; cyc();
      ev_buserr[1] = 1'b1; cyc();
      ev_eor[1] = 1'b1; cyc();
      rd_chk(4, 32'h207, "R4 flags");
      rd_chk(SUM_A, 32'h2, "R9 ch1");
      check("R10 irq high", 32'(irq), 1);

      // R5: write-one-to-clear
      wr(4, 0);
      rd_chk(4, 32'h207, "R5 zero keeps");
      wr(4, 32'h4);
      rd_chk(4, 32'h203, "R5 clear end");
      wr(4, 32'h203);
      rd_chk(4, 0, "R5 write-back");
      check("R10 irq low", 32'(irq), 0);

      // R6: event beats clear
      ev_end[1] = 1'b1;
      wr(4, 32'h4);
      rd_chk(4, 32'h4, "R6 event wins");
      wr(4, 32'h4);

      // R7: compare status
      wr(16, 32'h0200_0000);
      rd_chk(16, 32'h400, "R7 set");
      wr(16, 32'h0100_0000);
      rd_chk(16, 0, "R7 clear");
      wr(16, 32'h0300_0000);
      rd_chk(16, 32'h400, "R7 both");

      // R8, R11: decoding
      wr(4 * NCH, 32'hFFFF_FFFF);
      wr(2, 32'hFFFF_FFFF);
      wr(SUM_A, 32'hFFFF_FFFF);
      rd_chk(0, 32'hC000_0000, "R8 ch0 untouched");
      rd_chk(SUM_A, 0, "R8 summary untouched");
      rd_chk(4 * NCH, 0, "R11 unmapped");
      rd_chk(2, 0, "R11 misaligned");

      // R9: enables gate summary
      ev_eor[5] = 1'b1; cyc();
      rd_chk(SUM_A, 0, "R9 eor gated");
      wr(20, 32'h1000_0000);
      rd_chk(SUM_A, 32'h20, "R9 eor enabled");
      wr(8, 32'h2000_0000);
      rd_chk(SUM_A, 32'h24, "R9 stop enabled");
      check("R10 irq", 32'(irq), 1);
      stopped[2] = 1'b0; cyc();
      rd_chk(SUM_A, 32'h20, "R9 stop gone");

      // mixed traffic compared every clock
      r = 32'h1234_5678;
      for (int i = 0; i < 600; i++) begin
         int sel;
         r ^= r << 13; r ^= r >> 17; r ^= r << 5;
         sel = int'(r % 12);
         if (sel < 8)        addr = AW'(sel * 4);
         else if (sel == 8)  addr = AW'(SUM_A);
         else if (sel == 9)  addr = AW'(4 * NCH);
         else if (sel == 10) addr = AW'(4 * ((r >> 8) % NCH) + 1);
         else                addr = 0;
         wr_en = r[20] & r[21];
         ev_start  = NCH'(r >> 4) & NCH'(r >> 12);
         ev_end    = NCH'(r >> 6) & NCH'(r >> 14);
         ev_buserr = NCH'(r >> 9) & NCH'(r >> 17) & NCH'(r >> 25);
         ev_eor    = NCH'(r >> 3) & NCH'(r >> 19);
         if (r[30]) req_pend = NCH'(r >> 11);
         if (r[31]) stopped  = NCH'(r >> 22);
         r ^= r << 13; r ^= r >> 17; r ^= r << 5;
         wr_data = r[0] ? model_read(int'(addr)) : r;
         cyc();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule